// File: doc/BRIEF.md
# Vector Butterfly Permutation Unit

The unit rearranges the 128 sixteen-bit elements of a vector register with butterfly moves, one 256-bit slice of 16 elements per beat. A command names a direction (toward lower element numbers or toward higher ones), a distance taken from a register operand, and a vector length. Elements travel across that distance inside groups of twice the distance. Positions that receive nothing are cleared.

The register file sits outside the block. The unit fetches each source slice through a read port and returns one result slice per cycle through a write port that has per-element enables. Four 64-bit lanes cover short distances. Each lane has a shifter limited to 0, 16 or 32 bits, and two shared buses carry data between lanes. Distances of a slice or more turn into a reordering of whole slices. No full crossbar is used. The unit is used for fast reductions and FFT data shuffles.

Top module: `bfly_perm`

## Requirements
- R1: Direction 0 (left) with radix R writes dst[i] = src[i+R] where (i mod 2R) < R and writes 0 at every other position below the vector length. Element i sits in slice i/16 at bits [16*(i mod 16)+15 : 16*(i mod 16)].
- R2: Direction 1 (right) with radix R writes dst[i] = src[i-R] where (i mod 2R) >= R and writes 0 at every other position below the vector length.
- R3: A radix that is not a power of two from 1 to 64 raises radix_err for exactly the one cycle after acceptance. The unit then writes nothing, asserts no done and stays idle.
- R4: For a radix of 16, 32 or 64, each destination slice is either a whole source slice from R/16 slices away or all zeros. The slice is read through rd_addr.
- R5: With vector length L, the write of slice k enables element j (wr_be[j]) only when 16k+j < L. The unit performs ceil(L/16) writes. A length above 128 counts as 128. A length of 0 causes no write.
- R6: Slices are written one per cycle in ascending order from address 0. Slice k appears on the write port after the (k+1)-th rising edge that follows the accepting edge.
- R7: done is high for exactly one cycle, in the cycle after the last write: N+2 edges after acceptance for N writes. busy is high from acceptance through the done cycle.
- R8: While reset is asserted, busy, done, radix_err and wr_en are all low.
- R9: A command presented while busy is ignored, and the running operation finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_dir | input | 1 | 0 = move left, 1 = move right |
| cmd_radix | input | 7 | Butterfly distance in elements |
| cmd_vl | input | 8 | Vector length in elements |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| radix_err | output | 1 | One-cycle illegal-radix pulse |
| rd_en | output | 1 | Source slice read request |
| rd_addr | output | 3 | Source slice index |
| rd_data | input | 256 | Source slice, valid in the same cycle as rd_addr |
| wr_en | output | 1 | Destination slice write strobe |
| wr_addr | output | 3 | Destination slice index |
| wr_data | output | 256 | Destination slice data |
| wr_be | output | 16 | Per-element write enables |

## Verification
The assertions assume that rd_data returns the addressed slice combinationally in the same cycle. They also assume that reset is held for at least one edge before the first command. The bench models the read port as a combinational lookup into its own source array. It holds reset for several cycles and changes inputs only on falling edges. The assertions also assume that each command is presented with all its fields stable. Any intrusive command the bench sends during a run is held steady for several cycles and withdrawn before busy falls.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int ELEM_W      = 16;
  localparam int LANE_ELEMS  = 4;
  localparam int NUM_LANES   = 4;
  localparam int VREG_ELEMS  = 128;

  localparam int SLICE_ELEMS = LANE_ELEMS * NUM_LANES;
  localparam int LANE_W      = ELEM_W * LANE_ELEMS;
  localparam int SLICE_W     = LANE_W * NUM_LANES;
  localparam int NUM_SLICES  = VREG_ELEMS / SLICE_ELEMS;
  localparam int SLICE_AW    = $clog2(NUM_SLICES);
  localparam int RADIX_W     = $clog2(VREG_ELEMS);
  localparam int VL_W        = RADIX_W + 1;
  localparam int RL_W        = $clog2(RADIX_W);
  localparam int LOG_LANE    = $clog2(LANE_ELEMS);
  localparam int LOG_SLICE   = $clog2(SLICE_ELEMS);
  localparam int NUM_BUS     = NUM_LANES / 2;

  // six control cases: radix class x direction
  typedef enum logic [2:0] {
    PC_LANE_L, PC_LANE_R, PC_BUS_L, PC_BUS_R, PC_SLICE_L, PC_SLICE_R
  } pcase_e;
endpackage

// File: rtl/bfly_decode.sv
module bfly_decode
  import bfly_pkg::*;
(
  input  logic               dir_right,
  input  logic [RADIX_W-1:0] radix,
  output logic               legal,
  output pcase_e             pcase,
  output logic [RL_W-1:0]    rlog
);
  always_comb begin
    rlog = '0;
    for (int k = 0; k < RADIX_W; k++)
      if (radix[k]) rlog = RL_W'(k);
    legal = (radix != '0) && ((radix & (radix - RADIX_W'(1))) == '0);
    if (int'(rlog) < LOG_LANE)       pcase = dir_right ? PC_LANE_R  : PC_LANE_L;
    else if (int'(rlog) < LOG_SLICE) pcase = dir_right ? PC_BUS_R   : PC_BUS_L;
    else                             pcase = dir_right ? PC_SLICE_R : PC_SLICE_L;
  end
endmodule

// File: rtl/bfly_lane.sv
module bfly_lane
  import bfly_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic [LANE_W-1:0]              lane_in,
  input  logic [NUM_BUS-1:0][LANE_W-1:0] bus_in,
  input  pcase_e                         pcase,
  input  logic [RL_W-1:0]                rlog,
  output logic [LANE_W-1:0]              lane_out
);
  logic              to_left;
  logic [LANE_W-1:0] shifted;
  int                rl, half, bj;

  always_comb begin
    to_left  = (pcase == PC_LANE_L) || (pcase == PC_BUS_L) || (pcase == PC_SLICE_L);
    shifted  = lane_in;
    lane_out = '0;
    rl       = 0;
    half     = 0;
    bj       = 0;
    case (pcase)
      PC_LANE_L, PC_LANE_R: begin
        // shifter moves by 16 or 32 bits only
        shifted = to_left ? (lane_in >> (ELEM_W << rlog)) : (lane_in << (ELEM_W << rlog));
        for (int e = 0; e < LANE_ELEMS; e++)
          if (((e >> rlog) & 1) == (to_left ? 0 : 1))
            lane_out[e*ELEM_W +: ELEM_W] = shifted[e*ELEM_W +: ELEM_W];
      end
      PC_BUS_L, PC_BUS_R: begin
        rl   = int'(rlog) - LOG_LANE;
        half = (LANE_IDX >> rl) & 1;
        bj   = ((LANE_IDX >> (rl + 1)) << rl) | (LANE_IDX & ((1 << rl) - 1));
        if (((half == 0) == to_left) && (bj < NUM_BUS))
          lane_out = bus_in[bj];
      end
      default: lane_out = lane_in;
    endcase
  end
endmodule

// File: rtl/bfly_seq.sv
module bfly_seq
  import bfly_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                cmd_ok,
  input  logic [VL_W-1:0]     cmd_vl,
  output logic                accept,
  output logic                busy,
  output logic                run,
  output logic [SLICE_AW-1:0] beat,
  output logic [VL_W-1:0]     vl_eff,
  output logic                done,
  output logic                err
);
  logic                run_q, run_d, fin_q, fin_d, done_q, done_d, err_q, err_d;
  logic [SLICE_AW-1:0] beat_q, beat_d, last_q, last_d;
  logic [VL_W-1:0]     vl_q, vl_d, vl_sat, vl_round;
  logic [SLICE_AW:0]   nbeats;
  logic                ld_en;

  assign busy     = run_q | fin_q | done_q;
  assign accept   = cmd_valid & ~busy;
  assign vl_sat   = (cmd_vl > VL_W'(VREG_ELEMS)) ? VL_W'(VREG_ELEMS) : cmd_vl;
  assign vl_round = vl_sat + VL_W'(SLICE_ELEMS - 1);
  assign nbeats   = vl_round[VL_W-1:LOG_SLICE];
  assign ld_en    = accept & cmd_ok;

  always_comb begin
    run_d  = run_q;
    fin_d  = 1'b0;
    done_d = fin_q;
    err_d  = accept & ~cmd_ok;
    beat_d = beat_q;
    last_d = last_q;
    vl_d   = vl_q;
    if (ld_en) begin
      vl_d   = vl_sat;
      beat_d = '0;
      last_d = SLICE_AW'(nbeats - 1'b1);
      if (nbeats == '0) fin_d = 1'b1;
      else              run_d = 1'b1;
    end else if (run_q) begin
      beat_d = beat_q + 1'b1;
      if (beat_q == last_q) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      fin_q  <= fin_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      last_q <= '0;
      vl_q   <= '0;
    end else if (ld_en | run_q) begin
      beat_q <= beat_d;
      last_q <= last_d;
      vl_q   <= vl_d;
    end
  end

  assign run    = run_q;
  assign beat   = beat_q;
  assign vl_eff = vl_q;
  assign done   = done_q;
  assign err    = err_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q);
  // R3
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) err_q |-> !busy);
endmodule

// File: rtl/bfly_perm.sv
module bfly_perm
  import bfly_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic                   cmd_dir,
  input  logic [RADIX_W-1:0]     cmd_radix,
  input  logic [VL_W-1:0]        cmd_vl,
  output logic                   busy,
  output logic                   done,
  output logic                   radix_err,
  output logic                   rd_en,
  output logic [SLICE_AW-1:0]    rd_addr,
  input  logic [SLICE_W-1:0]     rd_data,
  output logic                   wr_en,
  output logic [SLICE_AW-1:0]    wr_addr,
  output logic [SLICE_W-1:0]     wr_data,
  output logic [SLICE_ELEMS-1:0] wr_be
);
  logic                accept, legal_in, run;
  pcase_e              pcase_in, pcase_q;
  logic [RL_W-1:0]     rlog_in, rlog_q;
  logic [SLICE_AW-1:0] beat;
  logic [VL_W-1:0]     vl_eff;
  logic                slice_left;
  logic [NUM_LANES-1:0][LANE_W-1:0] lane_src, lane_res;
  logic [NUM_BUS-1:0][LANE_W-1:0]   bus;
  logic                   wr_en_q;
  logic [SLICE_AW-1:0]    wr_addr_q;
  logic [SLICE_W-1:0]     wr_data_q;
  logic [SLICE_ELEMS-1:0] wr_be_q, be_d;
  int rs, rl, rcv, srcl;

  bfly_decode u_dec (
    .dir_right(cmd_dir), .radix(cmd_radix),
    .legal(legal_in), .pcase(pcase_in), .rlog(rlog_in)
  );

  bfly_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ok(legal_in),
    .cmd_vl(cmd_vl), .accept(accept), .busy(busy), .run(run), .beat(beat),
    .vl_eff(vl_eff), .done(done), .err(radix_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcase_q <= PC_LANE_L;
      rlog_q  <= '0;
    end else if (accept & legal_in) begin
      pcase_q <= pcase_in;
      rlog_q  <= rlog_in;
    end
  end

  // whole-slice reordering for large radices
  assign slice_left = (pcase_q == PC_SLICE_L);
  always_comb begin
    rd_addr = beat;
    rd_en   = run;
    rs      = 0;
    if ((pcase_q == PC_SLICE_L) || (pcase_q == PC_SLICE_R)) begin
      rs = int'(rlog_q) - LOG_SLICE;
      if ((((int'(beat) >> rs) & 1) == 0) == slice_left)
        rd_addr = slice_left ? SLICE_AW'(int'(beat) + (1 << rs))
                             : SLICE_AW'(int'(beat) - (1 << rs));
      else
        rd_en = 1'b0;
    end
  end

  assign lane_src = rd_en ? rd_data : '0;

  // shared buses: driven only for in-slice cross-lane radices
  always_comb begin
    bus  = '0;
    rl   = 0;
    rcv  = 0;
    srcl = 0;
    if ((pcase_q == PC_BUS_L) || (pcase_q == PC_BUS_R)) begin
      rl = int'(rlog_q) - LOG_LANE;
      for (int j = 0; j < NUM_BUS; j++) begin
        rcv  = ((j >> rl) << (rl + 1)) | (j & ((1 << rl) - 1));
        srcl = (pcase_q == PC_BUS_L) ? rcv + (1 << rl) : rcv;
        if (srcl < NUM_LANES) bus[j] = lane_src[srcl];
      end
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    bfly_lane #(.LANE_IDX(g)) u_lane (
      .lane_in(lane_src[g]), .bus_in(bus), .pcase(pcase_q),
      .rlog(rlog_q), .lane_out(lane_res[g])
    );
  end

  always_comb begin
    for (int k = 0; k < SLICE_ELEMS; k++)
      be_d[k] = VL_W'({beat, LOG_SLICE'(k)}) < vl_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_en_q <= 1'b0;
    else        wr_en_q <= run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_be_q   <= '0;
    end else if (run) begin
      wr_addr_q <= beat;
      wr_data_q <= lane_res;
      wr_be_q   <= be_d;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign wr_be   = wr_be_q;

  // R6
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_q && $past(wr_en_q)) |-> (wr_addr_q == $past(wr_addr_q) + 1'b1));
  // R5
  wr_first_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> wr_be_q[0]);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en_q);
  // R4
  slice_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ((pcase_q == PC_SLICE_L) || (pcase_q == PC_SLICE_R))) |-> (bus == '0));
endmodule

// File: tb/sim_bfly_perm.sv
`timescale 1ns/1ps
module sim_bfly_perm;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_dir;
  logic [6:0]   cmd_radix;
  logic [7:0]   cmd_vl;
  logic         busy, done, radix_err, rd_en, wr_en;
  logic [2:0]   rd_addr, wr_addr;
  logic [255:0] rd_data, wr_data;
  logic [15:0]  wr_be;

  logic [15:0] srcm [0:127];
  logic [15:0] dstm [0:127];
  int nchk = 0, nfail = 0, wr_cnt = 0, seed = 1;

  always #2.5 clk = ~clk;

  bfly_perm u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .cmd_radix(cmd_radix), .cmd_vl(cmd_vl), .busy(busy), .done(done),
    .radix_err(radix_err), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  always_comb
    for (int k = 0; k < 16; k++) rd_data[k*16 +: 16] = srcm[int'(rd_addr)*16 + k];

  always @(posedge clk)
    if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      for (int k = 0; k < 16; k++)
        if (wr_be[k]) dstm[int'(wr_addr)*16 + k] <= wr_data[k*16 +: 16];
    end

  // {dir, radix[6:0], vl[7:0]}
  localparam logic [15:0] VEC [0:17] = '{
    {1'b0, 7'd1, 8'd128},  {1'b1, 7'd1, 8'd128},  {1'b0, 7'd2, 8'd128},
    {1'b1, 7'd2, 8'd128},  {1'b0, 7'd4, 8'd128},  {1'b1, 7'd4, 8'd128},
    {1'b0, 7'd8, 8'd128},  {1'b1, 7'd8, 8'd128},  {1'b0, 7'd16, 8'd128},
    {1'b1, 7'd16, 8'd128}, {1'b0, 7'd32, 8'd128}, {1'b1, 7'd32, 8'd128},
    {1'b0, 7'd64, 8'd128}, {1'b1, 7'd64, 8'd128}, {1'b0, 7'd2, 8'd37},
    {1'b1, 7'd4, 8'd100},  {1'b0, 7'd32, 8'd50},  {1'b1, 7'd8, 8'd1}
  };

  function automatic logic [15:0] old_val(int i);
    return 16'h0BAD ^ 16'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 128; i++) begin
      srcm[i] = {1'b1, 15'(i*37 + seed*101)};
      dstm[i] = old_val(i);
    end
    seed++;
  endtask

  task automatic cmp_dst(input bit right, input int r, input int veff, input string tag);
    int bad = 0, fi = 0;
    logic [15:0] e, fe = '0;
    for (int i = 0; i < 128; i++) begin
      if (i >= veff) e = old_val(i);
      else if (r == 0) e = old_val(i);
      else if (!right) e = ((i % (2*r)) < r) ? srcm[i+r] : 16'h0;
      else             e = ((i % (2*r)) >= r) ? srcm[i-r] : 16'h0;
      if (dstm[i] !== e) begin
        if (bad == 0) begin fi = i; fe = e; end
        bad++;
      end
    end
    chk(bad == 0, tag, $sformatf("element %0d", fi), int'(dstm[fi]), int'(fe));
  endtask

  task automatic run_cmd(input bit right, input int r, input int vl, input bit intrude, input string tag);
    int c, nb, veff, wr0;
    fill();
    veff = (vl > 128) ? 128 : vl;
    nb   = (veff + 15) / 16;
    wr0  = wr_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dir = right; cmd_radix = 7'(r); cmd_vl = 8'(vl);
    @(posedge clk);
    @(negedge clk);
    c = 1;
    chk(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
    if (intrude) begin cmd_dir = ~right; cmd_radix = 7'd1; cmd_vl = 8'd128; end
    else cmd_valid = 1'b0;
    while (!done && c < 400) begin
      @(negedge clk);
      c++;
      if (c == 3) cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    chk(c == nb + 2, "R7", "done latency", c, nb + 2);
    chk(wr_cnt - wr0 == nb, "R6", "write count", wr_cnt - wr0, nb);
    @(negedge clk);
    chk(!done && !busy, "R7", "done single pulse", int'(done), 0);
    cmp_dst(right, r, veff, tag);
  endtask

  task automatic bad_radix(input int r);
    int wr0, dn;
    fill();
    wr0 = wr_cnt;
    dn  = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dir = 1'b0; cmd_radix = 7'(r); cmd_vl = 8'd128;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(radix_err == 1'b1, "R3", $sformatf("err raised radix %0d", r), int'(radix_err), 1);
    chk(busy == 1'b0, "R3", "stays idle", int'(busy), 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (done || radix_err) dn++;
    end
    chk(dn == 0, "R3", "no done, single err cycle", dn, 0);
    chk(wr_cnt == wr0, "R3", "no writes", wr_cnt - wr0, 0);
    cmp_dst(1'b0, 0, 0, "R3");
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_dir = 1'b0; cmd_radix = '0; cmd_vl = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!busy && !done && !radix_err && !wr_en, "R8", "reset outputs",
        int'({busy, done, radix_err, wr_en}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 18; v++) begin
      string tag;
      int r, l;
      r = int'(VEC[v][14:8]);
      l = int'(VEC[v][7:0]);
      if (l < 128)      tag = "R5";
      else if (r >= 16) tag = "R4";
      else if (VEC[v][15]) tag = "R2";
      else              tag = "R1";
      run_cmd(VEC[v][15], r, l, 1'b0, tag);
    end

    // corner cases
    run_cmd(1'b0, 4, 0, 1'b0, "R5");    // zero length
    run_cmd(1'b1, 2, 200, 1'b0, "R5");  // length saturates to 128
    run_cmd(1'b0, 8, 128, 1'b1, "R9");  // command while busy is ignored
    run_cmd(1'b1, 64, 16, 1'b1, "R9");
    bad_radix(3);
    bad_radix(0);
    bad_radix(96);
    bad_radix(127);
    run_cmd(1'b1, 1, 128, 1'b0, "R2");  // recovers after illegal radix

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule